// File: doc/BRIEF.md
# Register-Pair Load/Store Execution Unit

This block is the execution datapath of a small 8-bit accumulator machine. It fetches and executes instructions from address 0000h through one byte-wide synchronous memory port. It has an accumulator, six general byte registers grouped into three 16-bit pairs, and a five-bit flag register. The instruction subset covers 16-bit constant loads into a pair, direct and pair-indirect accumulator transfers, and direct transfers of the pointer pair as two bytes. It also covers moves between any byte register and the byte addressed by the pointer pair, 16-bit pair increment and decrement, and arithmetic on the byte addressed by the pointer pair.

Values of 16 bits cross the byte-wide port low byte first. Pair 2 (registers 4 and 5) is the implicit memory pointer. An unrecognised opcode stops the machine and raises a halt output. Register taps expose the architectural state so that it can be checked.

Top module: `rp_exec`

## Requirements
- R1: While rst_ni is low, the accumulator, all pairs and the flags read zero and halt_o is low. The first access after reset is a read at address 0000h.
- R2: Opcode 1p (p = 0, 1, 2) is followed by a low byte and then a high byte. The 16-bit value they form is written into pair p. In pair p, register 2p is the high byte and register 2p+1 is the low byte.
- R3: Opcode 60h (load) and opcode 61h (store) carry a 16-bit address, low byte first. The load copies that byte into the accumulator. The store writes the accumulator to that byte.
- R4: Opcode 62h reads the byte at the operand address into register 5 and the byte at the address plus one into register 4. Opcode 63h writes register 5 to the operand address and register 4 to the address plus one, and leaves the pair unchanged. The address plus one wraps from FFFFh to 0000h.
- R5: Opcode 8r copies the byte at the pointer-pair address into register r. Opcode 9r writes register r to that address. The register codes are 0 to 5 for the pair bytes and 7 for the accumulator.
- R6: Opcode 4p loads the accumulator from the address held in pair p. Opcode 5p stores the accumulator there. Only p = 0 and p = 1 are valid. The address pair is not altered.
- R7: Opcode 2p adds one to pair p and opcode 3p subtracts one from pair p, both modulo 65536, for p = 0, 1 or 2. The flags do not change.
- R8: Opcode A0h adds the pointer-addressed byte to the accumulator and opcode A1h subtracts it. Both write the result to the accumulator and update all flags. flags_o bits 4 to 0 are sign, zero, half-carry out of bit 3 (for subtraction, a borrow into bit 3), even parity, and carry (for subtraction, a borrow).
- R9: Opcode A2h increments and opcode A3h decrements the pointer-addressed byte in place. Sign, zero, half-carry and parity are updated. Carry keeps its value.
- R10: Any other opcode, including register code 6 in 8r or 9r, raises halt_o. halt_o then stays high, and no further memory access or register change occurs.
- R11: Each cycle has at most one memory access, never a read and a write together. Read data is taken one cycle after the read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_addr_o | output | 16 | Memory byte address |
| mem_rd_o | output | 1 | Read strobe; data returns next cycle |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, one cycle after mem_rd_o |
| halt_o | output | 1 | Execution stopped on an unknown opcode |
| acc_o | output | 8 | Accumulator tap |
| pair0_o | output | 16 | Pair 0 tap {reg0, reg1} |
| pair1_o | output | 16 | Pair 1 tap {reg2, reg3} |
| pair2_o | output | 16 | Pointer pair tap {reg4, reg5} |
| flags_o | output | 5 | {sign, zero, half-carry, parity, carry} |

## Verification
The assertions take for granted that the memory returns data exactly one cycle after a read strobe and that mem_rdata_i holds a defined value whenever a read is pending. The bench memory model is a registered array that answers every read strobe on the next edge. Directed programs drive the wrap, flag and halt corners. Random programs are built only from valid opcodes, with pointers and direct addresses drawn from a preloaded data window, and each ends in an illegal opcode so that every run reaches the halt state.

// File: rtl/rp_pkg.sv
package rp_pkg;
  localparam int DW   = 8;
  localparam int AW   = 16;
  localparam int NREG = 8;
  localparam int NFL  = 5;
  localparam int RIW  = $clog2(NREG);

  localparam int REG_ACC = 7;
  localparam int REG_PH  = 4;
  localparam int REG_PL  = 5;

  localparam int FL_CY = 0;
  localparam int FL_P  = 1;
  localparam int FL_AC = 2;
  localparam int FL_Z  = 3;
  localparam int FL_S  = 4;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_IMM1, ST_IMM2,
    ST_RD, ST_RD2, ST_WR2, ST_HALT
  } state_e;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_INC, ALU_DEC} alu_op_e;

  typedef struct packed {
    logic ldi, inx, dcx, ldx, stx;
    logic lda, sta, lhl, shl;
    logic mrd, mwr, alu, bad;
    logic [1:0] pair;
    logic [RIW-1:0] ridx;
    alu_op_e aop;
  } dec_t;
endpackage

// File: rtl/rp_decode.sv
module rp_decode
  import rp_pkg::*;
(
  input  logic [DW-1:0] ir_i,
  output dec_t          dec_o
);
  logic [3:0] hi, lo;
  logic       any;

  always_comb begin
    hi = ir_i[7:4];
    lo = ir_i[3:0];
    dec_o      = '0;
    dec_o.pair = ir_i[1:0];
    dec_o.ridx = ir_i[RIW-1:0];
    dec_o.aop  = alu_op_e'(ir_i[1:0]);
    dec_o.ldi  = (hi == 4'h1) && (lo < 4'd3);
    dec_o.inx  = (hi == 4'h2) && (lo < 4'd3);
    dec_o.dcx  = (hi == 4'h3) && (lo < 4'd3);
    dec_o.ldx  = (hi == 4'h4) && (lo < 4'd2);
    dec_o.stx  = (hi == 4'h5) && (lo < 4'd2);
    dec_o.lda  = (ir_i == 8'h60);
    dec_o.sta  = (ir_i == 8'h61);
    dec_o.lhl  = (ir_i == 8'h62);
    dec_o.shl  = (ir_i == 8'h63);
    // register code 6 is not a register
    dec_o.mrd  = (hi == 4'h8) && (lo < 4'd8) && (lo != 4'd6);
    dec_o.mwr  = (hi == 4'h9) && (lo < 4'd8) && (lo != 4'd6);
    dec_o.alu  = (hi == 4'hA) && (lo < 4'd4);
    any = dec_o.ldi | dec_o.inx | dec_o.dcx | dec_o.ldx | dec_o.stx |
          dec_o.lda | dec_o.sta | dec_o.lhl | dec_o.shl |
          dec_o.mrd | dec_o.mwr | dec_o.alu;
    dec_o.bad  = !any;
  end
endmodule

// File: rtl/rp_alu.sv
module rp_alu
  import rp_pkg::*;
(
  input  alu_op_e        op_i,
  input  logic [DW-1:0]  acc_i,
  input  logic [DW-1:0]  mem_i,
  input  logic           cy_i,
  output logic [DW-1:0]  res_o,
  output logic [NFL-1:0] flags_o
);
  logic [DW:0] wide;
  logic [4:0]  nib;
  logic        ac, cy;

  always_comb begin
    wide = '0;
    nib  = '0;
    ac   = 1'b0;
    cy   = cy_i;
    unique case (op_i)
      ALU_ADD: begin
        wide = {1'b0, acc_i} + {1'b0, mem_i};
        nib  = {1'b0, acc_i[3:0]} + {1'b0, mem_i[3:0]};
        ac   = nib[4];
        cy   = wide[DW];
      end
      ALU_SUB: begin
        wide = {1'b0, acc_i} - {1'b0, mem_i};
        nib  = {1'b0, acc_i[3:0]} - {1'b0, mem_i[3:0]};
        ac   = nib[4];
        cy   = wide[DW];
      end
      ALU_INC: begin
        wide = {1'b0, mem_i} + 9'd1;
        ac   = (mem_i[3:0] == 4'hF);
      end
      default: begin
        wide = {1'b0, mem_i} - 9'd1;
        ac   = (mem_i[3:0] == 4'h0);
      end
    endcase
    res_o          = wide[DW-1:0];
    flags_o[FL_S]  = res_o[DW-1];
    flags_o[FL_Z]  = (res_o == '0);
    flags_o[FL_AC] = ac;
    flags_o[FL_P]  = ~^res_o;
    flags_o[FL_CY] = cy;
  end
endmodule

// File: rtl/rp_regfile.sv
module rp_regfile
  import rp_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [RIW-1:0]           wr_idx_i,
  input  logic [DW-1:0]            wr_data_i,
  input  logic                     pw_en_i,
  input  logic [1:0]               pw_sel_i,
  input  logic [2*DW-1:0]          pw_data_i,
  input  logic                     fl_en_i,
  input  logic [NFL-1:0]           fl_data_i,
  output logic [NREG-1:0][DW-1:0]  regs_o,
  output logic [NFL-1:0]           flags_o
);
  logic [NREG-1:0][DW-1:0] regs_q;
  logic [NFL-1:0]          flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q  <= '0;
      flags_q <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wr_en_i && (wr_idx_i == RIW'(i)))
          regs_q[i] <= wr_data_i;
        else if (pw_en_i && (pw_sel_i == 2'(i >> 1)))
          regs_q[i] <= (i % 2 == 0) ? pw_data_i[2*DW-1:DW] : pw_data_i[DW-1:0];
      end
      if (fl_en_i) flags_q <= fl_data_i;
    end
  end

  assign regs_o  = regs_q;
  assign flags_o = flags_q;

  AST_ONE_WRITER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && pw_en_i)); // R2
endmodule

// File: rtl/rp_exec.sv
module rp_exec
  import rp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [AW-1:0]     mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              halt_o,
  output logic [DW-1:0]     acc_o,
  output logic [2*DW-1:0]   pair0_o,
  output logic [2*DW-1:0]   pair1_o,
  output logic [2*DW-1:0]   pair2_o,
  output logic [NFL-1:0]    flags_o
);
  state_e                  state_q, state_d;
  logic [AW-1:0]           pc_q, ea_q, addr16, ptr, pval;
  logic [DW-1:0]           ir_q, tmp_q, alu_res;
  logic                    pc_inc, ir_ld, tmp_ld, ea_ld;
  dec_t                    dec;
  logic [NREG-1:0][DW-1:0] regs;
  logic [NFL-1:0]          flags, alu_fl;
  logic                    wr_en, pw_en, fl_en;
  logic [RIW-1:0]          wr_idx;
  logic [DW-1:0]           wr_data;
  logic [2*DW-1:0]         pw_data;

  rp_decode u_dec (.ir_i(ir_q), .dec_o(dec));

  rp_alu u_alu (
    .op_i(dec.aop), .acc_i(regs[REG_ACC]), .mem_i(mem_rdata_i),
    .cy_i(flags[FL_CY]), .res_o(alu_res), .flags_o(alu_fl)
  );

  rp_regfile u_rf (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .pw_en_i(pw_en), .pw_sel_i(dec.pair), .pw_data_i(pw_data),
    .fl_en_i(fl_en), .fl_data_i(alu_fl),
    .regs_o(regs), .flags_o(flags)
  );

  assign addr16 = {mem_rdata_i, tmp_q};  // little-endian operand
  assign ptr    = {regs[REG_PH], regs[REG_PL]};

  always_comb begin
    unique case (dec.pair)
      2'd0:    pval = {regs[0], regs[1]};
      2'd1:    pval = {regs[2], regs[3]};
      default: pval = {regs[4], regs[5]};
    endcase
  end

  always_comb begin
    state_d     = state_q;
    mem_addr_o  = pc_q;
    mem_rd_o    = 1'b0;
    mem_wr_o    = 1'b0;
    mem_wdata_o = '0;
    pc_inc = 1'b0; ir_ld = 1'b0; tmp_ld = 1'b0; ea_ld = 1'b0;
    wr_en  = 1'b0; wr_idx = '0; wr_data = '0;
    pw_en  = 1'b0; pw_data = '0; fl_en = 1'b0;
    unique case (state_q)
      ST_FETCH: begin
        mem_rd_o = 1'b1; pc_inc = 1'b1; state_d = ST_DECODE;
      end
      ST_DECODE: begin
        ir_ld = 1'b1; state_d = ST_EXEC;
      end
      ST_EXEC: begin
        if (dec.bad) state_d = ST_HALT;
        else if (dec.ldi | dec.lda | dec.sta | dec.lhl | dec.shl) begin
          mem_rd_o = 1'b1; pc_inc = 1'b1; state_d = ST_IMM1;
        end else if (dec.inx | dec.dcx) begin
          pw_en   = 1'b1;
          pw_data = dec.inx ? pval + 16'd1 : pval - 16'd1;
          state_d = ST_FETCH;
        end else if (dec.ldx) begin
          mem_addr_o = pval; mem_rd_o = 1'b1; state_d = ST_RD;
        end else if (dec.stx) begin
          mem_addr_o = pval; mem_wr_o = 1'b1;
          mem_wdata_o = regs[REG_ACC]; state_d = ST_FETCH;
        end else if (dec.mwr) begin
          mem_addr_o = ptr; mem_wr_o = 1'b1;
          mem_wdata_o = regs[dec.ridx]; state_d = ST_FETCH;
        end else begin
          mem_addr_o = ptr; mem_rd_o = 1'b1; state_d = ST_RD;
        end
      end
      ST_IMM1: begin
        tmp_ld = 1'b1; mem_rd_o = 1'b1; pc_inc = 1'b1; state_d = ST_IMM2;
      end
      ST_IMM2: begin
        ea_ld = 1'b1;
        state_d = ST_FETCH;
        if (dec.ldi) begin
          pw_en = 1'b1; pw_data = addr16;
        end else if (dec.sta) begin
          mem_addr_o = addr16; mem_wr_o = 1'b1; mem_wdata_o = regs[REG_ACC];
        end else if (dec.shl) begin
          mem_addr_o = addr16; mem_wr_o = 1'b1; mem_wdata_o = regs[REG_PL];
          state_d = ST_WR2;
        end else begin
          mem_addr_o = addr16; mem_rd_o = 1'b1; state_d = ST_RD;
        end
      end
      ST_RD: begin
        state_d = ST_FETCH;
        if (dec.lhl) begin
          wr_en = 1'b1; wr_idx = RIW'(REG_PL); wr_data = mem_rdata_i;
          mem_addr_o = ea_q; mem_rd_o = 1'b1; state_d = ST_RD2;
        end else if (dec.mrd) begin
          wr_en = 1'b1; wr_idx = dec.ridx; wr_data = mem_rdata_i;
        end else if (dec.alu) begin
          fl_en = 1'b1;
          if (dec.aop == ALU_ADD || dec.aop == ALU_SUB) begin
            wr_en = 1'b1; wr_idx = RIW'(REG_ACC); wr_data = alu_res;
          end else begin
            mem_addr_o = ptr; mem_wr_o = 1'b1; mem_wdata_o = alu_res;
          end
        end else begin
          wr_en = 1'b1; wr_idx = RIW'(REG_ACC); wr_data = mem_rdata_i;
        end
      end
      ST_RD2: begin
        wr_en = 1'b1; wr_idx = RIW'(REG_PH); wr_data = mem_rdata_i;
        state_d = ST_FETCH;
      end
      ST_WR2: begin
        mem_addr_o = ea_q; mem_wr_o = 1'b1; mem_wdata_o = regs[REG_PH];
        state_d = ST_FETCH;
      end
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
      tmp_q   <= '0;
      ea_q    <= '0;
    end else begin
      state_q <= state_d;
      if (pc_inc) pc_q  <= pc_q + 16'd1;
      if (ir_ld)  ir_q  <= mem_rdata_i;
      if (tmp_ld) tmp_q <= mem_rdata_i;
      if (ea_ld)  ea_q  <= addr16 + 16'd1;  // wraps at FFFFh
    end
  end

  assign halt_o  = (state_q == ST_HALT);
  assign acc_o   = regs[REG_ACC];
  assign pair0_o = {regs[0], regs[1]};
  assign pair1_o = {regs[2], regs[3]};
  assign pair2_o = ptr;
  assign flags_o = flags;

  AST_RW_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o)); // R11
  AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !mem_rd_o && !mem_wr_o); // R10
  AST_HALT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o && $stable(acc_o) && $stable(pair2_o)); // R10
  AST_PAIR_NOFLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXEC && (dec.inx || dec.dcx)) |=> $stable(flags_o)); // R7
  AST_STX_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXEC && dec.stx) |=> $stable(pair0_o) && $stable(pair1_o)); // R6
  AST_SHL_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IMM2 && dec.shl) |=> $stable(pair2_o)); // R4
  AST_INCM_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD && dec.alu && (dec.aop == ALU_INC || dec.aop == ALU_DEC))
    |=> flags_o[FL_CY] == $past(flags_o[FL_CY])); // R9
endmodule

// File: tb/rp_exec_bench.sv
module rp_exec_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, halt;
  logic [7:0]  mem_wdata, mem_rdata, acc;
  logic [15:0] p0, p1, p2;
  logic [4:0]  flags;

  always #4 clk = ~clk;

  rp_exec u_rp_exec (
    .clk_i(clk), .rst_ni(rst_n),
    .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .halt_o(halt), .acc_o(acc), .pair0_o(p0), .pair1_o(p1), .pair2_o(p2),
    .flags_o(flags)
  );

  // DUT memory, aliased to 4 KiB
  logic [7:0]  dmem [4096];
  logic        clr_en = 1'b0, ld_en = 1'b0;
  logic [11:0] ld_a = '0;
  logic [7:0]  ld_d = '0;
  int          clash = 0;

  always @(posedge clk) begin
    if (clr_en) for (int i = 0; i < 4096; i++) dmem[i] <= 8'h00;
    else if (ld_en) dmem[ld_a] <= ld_d;
    else if (mem_wr) dmem[mem_addr[11:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= dmem[mem_addr[11:0]];
    if (rst_n && mem_rd && mem_wr) clash <= clash + 1;
  end

  // reference state
  logic [7:0] mmem [4096];
  logic [7:0] mr [8];
  logic [4:0] mf;
  logic [7:0] prog [256];
  int         plen;
  logic [11:0] pk_a [64];
  logic [7:0]  pk_d [64];
  int         npk;
  int         total = 0, fails = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic emit(logic [7:0] b);
    prog[plen] = b; plen++;
  endtask
  task automatic emit3(logic [7:0] op, logic [15:0] w);
    emit(op); emit(w[7:0]); emit(w[15:8]);
  endtask
  task automatic poke(logic [11:0] a, logic [7:0] d);
    pk_a[npk] = a; pk_d[npk] = d; npk++;
  endtask
  task automatic new_prog();
    plen = 0; npk = 0;
  endtask

  function automatic logic [15:0] gp(int p);
    return {mr[2*p], mr[2*p+1]};
  endfunction
  task automatic sp(int p, logic [15:0] v);
    mr[2*p] = v[15:8]; mr[2*p+1] = v[7:0];
  endtask
  function automatic logic [4:0] mkfl(logic [7:0] r, bit ac, bit cy);
    return {r[7], r == 8'h00, ac, ~^r, cy};
  endfunction

  task automatic iss_run();
    logic [15:0] pc, w;
    logic [7:0]  op, m, res;
    bit          mh, ac, cy;
    for (int i = 0; i < 8; i++) mr[i] = 8'h00;
    mf = '0; pc = '0; mh = 1'b0; w = '0;
    for (int st = 0; st < 2000; st++) begin
      if (mh) break;
      op = mmem[pc[11:0]]; pc = pc + 16'd1;
      if ((op[7:4] == 4'h1 && op[3:0] < 4'd3) || (op >= 8'h60 && op <= 8'h63)) begin
        w[7:0] = mmem[pc[11:0]]; pc = pc + 16'd1;
        w[15:8] = mmem[pc[11:0]]; pc = pc + 16'd1;
      end
      if (op[7:4] == 4'h1 && op[3:0] < 4'd3) sp(int'(op[1:0]), w);
      else if (op[7:4] == 4'h2 && op[3:0] < 4'd3) sp(int'(op[1:0]), gp(int'(op[1:0])) + 16'd1);
      else if (op[7:4] == 4'h3 && op[3:0] < 4'd3) sp(int'(op[1:0]), gp(int'(op[1:0])) - 16'd1);
      else if (op[7:4] == 4'h4 && op[3:0] < 4'd2) mr[7] = mmem[gp(int'(op[1:0])) & 16'h0FFF];
      else if (op[7:4] == 4'h5 && op[3:0] < 4'd2) mmem[gp(int'(op[1:0])) & 16'h0FFF] = mr[7];
      else if (op == 8'h60) mr[7] = mmem[w[11:0]];
      else if (op == 8'h61) mmem[w[11:0]] = mr[7];
      else if (op == 8'h62) begin
        mr[5] = mmem[w[11:0]]; w = w + 16'd1; mr[4] = mmem[w[11:0]];
      end else if (op == 8'h63) begin
        mmem[w[11:0]] = mr[5]; w = w + 16'd1; mmem[w[11:0]] = mr[4];
      end else if (op[7:4] == 4'h8 && op[3:0] < 4'd8 && op[3:0] != 4'd6)
        mr[op[2:0]] = mmem[gp(2) & 16'h0FFF];
      else if (op[7:4] == 4'h9 && op[3:0] < 4'd8 && op[3:0] != 4'd6)
        mmem[gp(2) & 16'h0FFF] = mr[op[2:0]];
      else if (op[7:4] == 4'hA && op[3:0] < 4'd4) begin
        m = mmem[gp(2) & 16'h0FFF];
        cy = mf[0];
        case (op[1:0])
          2'd0: begin
            res = mr[7] + m; cy = (int'(mr[7]) + int'(m)) > 255;
            ac = (int'(mr[7][3:0]) + int'(m[3:0])) > 15; mr[7] = res;
          end
          2'd1: begin
            res = mr[7] - m; cy = mr[7] < m; ac = mr[7][3:0] < m[3:0]; mr[7] = res;
          end
          2'd2: begin
            res = m + 8'd1; ac = (m[3:0] == 4'hF); mmem[gp(2) & 16'h0FFF] = res;
          end
          default: begin
            res = m - 8'd1; ac = (m[3:0] == 4'h0); mmem[gp(2) & 16'h0FFF] = res;
          end
        endcase
        mf = mkfl(res, ac, cy);
      end else mh = 1'b1;
    end
  endtask

  task automatic load_byte(logic [11:0] a, logic [7:0] d);
    ld_en = 1'b1; ld_a = a; ld_d = d; mmem[a] = d;
    @(negedge clk);
  endtask

  task automatic run_prog(string req);
    int cyc, bad;
    rst_n = 1'b0;
    @(negedge clk);
    clr_en = 1'b1;
    for (int i = 0; i < 4096; i++) mmem[i] = 8'h00;
    @(negedge clk);
    clr_en = 1'b0;
    for (int i = 0; i < 64; i++) load_byte(12'h900 + 12'(i), 8'($urandom));
    for (int i = 0; i < npk; i++) load_byte(pk_a[i], pk_d[i]);
    for (int i = 0; i < plen; i++) load_byte(12'(i), prog[i]);
    ld_en = 1'b0;
    iss_run();
    // R1: reset state of the taps
    chk("R1", "reset acc", {24'h0, acc}, 32'h0);
    chk("R1", "reset pairs", {p0 | p1 | p2, 16'h0}, 32'h0);
    chk("R1", "reset flags/halt", {26'h0, flags, halt}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "first read addr0", {15'h0, mem_rd, mem_addr}, {15'h0, 1'b1, 16'h0000});
    cyc = 0;
    while (!halt && cyc < 4000) begin
      @(negedge clk);
      cyc++;
    end
    chk("R10", "halt reached", {31'h0, halt}, 32'h1);
    repeat (5) @(negedge clk);
    chk("R10", "halt held", {31'h0, halt}, 32'h1);
    chk(req, "acc", {24'h0, acc}, {24'h0, mr[7]});
    chk(req, "pair0", {16'h0, p0}, {16'h0, gp(0)});
    chk(req, "pair1", {16'h0, p1}, {16'h0, gp(1)});
    chk(req, "pair2", {16'h0, p2}, {16'h0, gp(2)});
    chk(req, "flags", {27'h0, flags}, {27'h0, mf});
    bad = 0;
    for (int i = 0; i < 4096; i++) if (dmem[i] !== mmem[i]) bad++;
    chk(req, "memory mismatches", bad, 0);
    chk("R11", "read/write clash cycles", clash, 0);
  endtask

  function automatic logic [15:0] dptr();
    return {4'($urandom), 4'h9, 2'b00, 6'($urandom)};
  endfunction

  task automatic rand_prog();
    int k;
    new_prog();
    emit3(8'h10, dptr()); emit3(8'h11, dptr()); emit3(8'h12, dptr());
    emit3(8'h60, dptr());
    for (int n = 0; n < 25; n++) begin
      k = int'($urandom % 12);
      case (k)
        0:  emit3(8'h10 + 8'($urandom % 3), dptr());
        1:  emit(8'h20 + 8'($urandom % 3));
        2:  emit(8'h30 + 8'($urandom % 3));
        3:  emit(8'h40 + 8'($urandom % 2));
        4:  emit(8'h50 + 8'($urandom % 2));
        5:  emit3(8'h60, dptr());
        6:  emit3(8'h61, dptr());
        7:  emit3(8'h62, dptr());
        8:  emit3(8'h63, dptr());
        9:  emit(8'h80 + (($urandom % 2 == 0) ? 8'h07 : 8'($urandom % 6)));
        10: emit(8'h90 + (($urandom % 2 == 0) ? 8'h07 : 8'($urandom % 6)));
        default: emit(8'hA0 + 8'($urandom % 4));
      endcase
    end
    emit(8'hFF);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    // R2: immediate pair loads
    new_prog();
    emit3(8'h10, 16'h1234); emit3(8'h11, 16'hABCD); emit3(8'h12, 16'h00FF); emit(8'hFF);
    run_prog("R2");
    // R3: direct accumulator load/store
    new_prog(); poke(12'h950, 8'h5A);
    emit3(8'h60, 16'h0950); emit3(8'h61, 16'h0A7F); emit(8'hFF);
    run_prog("R3");
    // R4: direct pointer-pair load/store across FFFFh
    new_prog(); poke(12'hFFF, 8'h3C);
    emit3(8'h62, 16'hFFFF); emit3(8'h10, 16'h2211); emit(8'h85);
    emit3(8'h12, 16'h1234); emit3(8'h63, 16'hFFFF); emit(8'hFF);
    run_prog("R4");
    // R5: moves through the pointer pair
    new_prog(); poke(12'h900, 8'h77);
    emit3(8'h12, 16'h0900); emit(8'h80); emit(8'h87);
    emit3(8'h12, 16'h0901); emit(8'h95); emit3(8'h10, 16'h5544); emit(8'h91);
    emit(8'h94); emit(8'h83); emit(8'hFF);
    run_prog("R5");
    // R6: indirect accumulator through pairs 0 and 1
    new_prog(); poke(12'h910, 8'hA5); poke(12'h920, 8'h3B);
    emit3(8'h10, 16'h0910); emit3(8'h11, 16'h0920);
    emit(8'h41); emit(8'h50); emit(8'h40); emit(8'hFF);
    run_prog("R6");
    // R7: pair increment/decrement wrap, flags kept
    new_prog(); poke(12'h900, 8'hFF);
    emit3(8'h12, 16'h0900); emit(8'hA0);
    emit3(8'h10, 16'hFFFF); emit(8'h20); emit3(8'h11, 16'h0000); emit(8'h31);
    emit(8'h22); emit(8'h32); emit(8'h32); emit(8'hFF);
    run_prog("R7");
    // R8: add with carry out and zero
    new_prog(); poke(12'h900, 8'h80);
    emit3(8'h60, 16'h0900); emit3(8'h12, 16'h0900); emit(8'hA0); emit(8'hFF);
    run_prog("R8");
    // R8: half-carry on add
    new_prog(); poke(12'h901, 8'h0F); poke(12'h902, 8'h01);
    emit3(8'h60, 16'h0901); emit3(8'h12, 16'h0902); emit(8'hA0); emit(8'hFF);
    run_prog("R8");
    // R8: subtract borrow
    new_prog(); poke(12'h900, 8'h01);
    emit3(8'h12, 16'h0900); emit(8'hA1); emit(8'hFF);
    run_prog("R8");
    // R9: increment FFh to 00h with carry set
    new_prog(); poke(12'h900, 8'h01); poke(12'h903, 8'hFF);
    emit3(8'h12, 16'h0900); emit(8'hA1); emit3(8'h12, 16'h0903); emit(8'hA2); emit(8'hFF);
    run_prog("R9");
    // R9: decrement 00h to FFh with carry clear
    new_prog(); poke(12'h904, 8'h00);
    emit3(8'h12, 16'h0904); emit(8'hA3); emit(8'hA3); emit(8'hFF);
    run_prog("R9");
    // R10: register code 6 halts before a later store
    new_prog();
    emit3(8'h10, 16'h0201); emit3(8'h12, 16'h0905); emit(8'h86); emit(8'h91); emit(8'hFF);
    run_prog("R10");
    // R10: pair code 3 halts
    new_prog();
    emit3(8'h10, 16'h0A0B); emit(8'h13); emit(8'h20); emit(8'hFF);
    run_prog("R10");
    for (int t = 0; t < 20; t++) begin
      rand_prog();
      run_prog("R5");
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule